// File: doc/BRIEF.md
# Reset Cause and Level-Monitor Controller

This block records why a microcontroller was last reset and sets how a supply-level monitor reacts when it trips. There are three sticky cause flags: power-on, external pin and watchdog. Each one is set by a one-cycle event input. Software reads the flags through a byte-wide register port and clears each one on its own by writing a zero to its bit. The power-on flag survives every other reset source. The external and watchdog flags are wiped by any power-on, so after a reset the flags show the most recent cause.

A second register holds a 3-bit level-monitor code, an interrupt enable and a monitor flag. The code decides what a trip pulse on the monitor input does:

- It can be ignored.
- It can become a power-on-style reset request. The request pulses the reset output and updates the cause flags in the same way as a true power-on.
- It can set the monitor flag. The interrupt output is that flag ANDed with the enable.

Writes of codes that are not allowed are refused, and the last legal code is kept. The comparator, the reset pulse stretcher and the bus fabric sit outside this block.

Top module: `rcm_top`

## Requirements
- R1: Register select 0 reads the status byte: bit 3 is the watchdog flag, bit 1 the external flag, bit 0 the power-on flag, and bits 7:4 and 2 always read zero whatever is written. Select 1 reads the control byte: bits 2:0 are the monitor code, bit 3 the interrupt enable, bit 7 the monitor flag, and the other bits read zero.
- R2: The power-on flag is set one cycle after a power-on event or a reset-mode monitor trip. It is cleared only by writing zero to status bit 0.
- R3: The watchdog and external flags are set one cycle after their own event. Each is cleared by a power-on event, by a reset-mode monitor trip, or by writing zero to its status bit.
- R4: Writing a one to any flag bit leaves that flag unchanged. When a set event and a clear land in the same cycle, the flag ends up set.
- R5: With monitor code 000, trips have no effect on any output or register.
- R6: With codes 001 or 010, a trip drives the reset-request output high in the next cycle and leaves the monitor flag unchanged.
- R7: With codes 011 or 100, a trip sets the monitor flag in the next cycle and does not raise a reset request. The interrupt output equals the monitor flag ANDed with the enable bit.
- R8: A control write whose code field is 101, 110 or 111 keeps the previous code. The enable bit and the flag-clear bit of that write still take effect.
- R9: After the block reset, both registers read zero and the reset-request and interrupt outputs are low.
- R10: Writing zero to control bit 7 clears the monitor flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_evt | input | 1 | Power-on event pulse |
| ext_evt | input | 1 | External-pin reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| lvm_trip | input | 1 | Level-monitor trip pulse |
| reg_sel | input | 1 | Register select: 0 status, 1 control |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| por_req | output | 1 | Reset request caused by a monitor trip |
| lvm_flag | output | 1 | Monitor flag |
| lvm_irq | output | 1 | Monitor interrupt |

## Verification
The hardest situations to reach are the cycles where a set and a clear collide. Examples are a trip that sets the monitor flag while software writes zero to it, and a watchdog event that arrives in the same cycle as a status write clearing every flag. The vector table drives both sources on the same edge and then reads the registers back. A refused code write that also carries a legal enable change and a flag clear is covered the same way. Reset-mode trips are applied while the external or watchdog flag is set, to show that those flags are wiped.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
   typedef enum logic [1:0] {
      MON_OFF = 2'd0,
      MON_RST = 2'd1,
      MON_IRQ = 2'd2,
      MON_BAD = 2'd3
   } mon_mode_e;

   localparam int SRC_NUM = 3;
   localparam int SRC_POR = 0;
   localparam int SRC_EXT = 1;
   localparam int SRC_WDT = 2;
endpackage

// File: rtl/rcm_flag.sv
module rcm_flag #(
   parameter bit CLR_ON_POR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic por_i,
   input  logic sw_clr_i,
   output logic q_o
);
   logic clr;

   generate
      if (CLR_ON_POR) begin : g_por_clr
         assign clr = sw_clr_i | por_i;
      end else begin : g_sw_clr
         logic unused_por;
         assign unused_por = por_i;
         assign clr = sw_clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr)   q_o <= 1'b0;
   end
endmodule

// File: rtl/rcm_lvm.sv
module rcm_lvm
   import rcm_pkg::*;
#(
   parameter int DW       = 8,
   parameter int CODE_W   = 3,
   parameter int IEN_BIT  = 3,
   parameter int FLAG_BIT = 7,
   parameter int RST_LO   = 1,
   parameter int RST_HI   = 2,
   parameter int IRQ_LO   = 3,
   parameter int IRQ_HI   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              trip_i,
   output logic [CODE_W-1:0] code_o,
   output logic              ien_o,
   output logic              flag_o,
   output logic              por_trip_o,
   output logic              por_req_o
);
   localparam int MAX_CODE = IRQ_HI;

   logic [CODE_W-1:0] wr_code;
   logic              code_ok;
   mon_mode_e         mode;
   logic              flag_set;
   logic              flag_clr;

   if (RST_LO < 1 || RST_HI < RST_LO || IRQ_LO <= RST_HI || IRQ_HI < IRQ_LO) begin : g_bad_range
      $error("rcm_lvm: code ranges must be ordered and exclude zero");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code_w
      $error("rcm_lvm: code field too narrow");
   end

   assign wr_code = wdata_i[CODE_W-1:0];
   assign code_ok = 32'(wr_code) <= MAX_CODE;

   always_comb begin
      if (32'(code_o) == 0)
         mode = MON_OFF;
      else if (32'(code_o) >= RST_LO && 32'(code_o) <= RST_HI)
         mode = MON_RST;
      else if (32'(code_o) >= IRQ_LO && 32'(code_o) <= IRQ_HI)
         mode = MON_IRQ;
      else
         mode = MON_BAD;
   end

   assign por_trip_o = trip_i && (mode == MON_RST);
   assign flag_set   = trip_i && (mode == MON_IRQ);
   assign flag_clr   = wr_i && !wdata_i[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o    <= '0;
         ien_o     <= 1'b0;
         por_req_o <= 1'b0;
      end else begin
         por_req_o <= por_trip_o;
         if (wr_i) begin
            ien_o <= wdata_i[IEN_BIT];
            if (code_ok) code_o <= wr_code;
         end
      end
   end

   rcm_flag #(.CLR_ON_POR(1'b0)) u_mflag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (flag_set),
      .por_i   (1'b0),
      .sw_clr_i(flag_clr),
      .q_o     (flag_o)
   );
endmodule

// File: rtl/rcm_top.sv
module rcm_top
   import rcm_pkg::*;
#(
   parameter int DW       = 8,
   parameter int POR_BIT  = 0,
   parameter int EXT_BIT  = 1,
   parameter int WDT_BIT  = 3,
   parameter int CODE_W   = 3,
   parameter int IEN_BIT  = 3,
   parameter int FLAG_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_evt,
   input  logic          ext_evt,
   input  logic          wdt_evt,
   input  logic          lvm_trip,
   input  logic          reg_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output logic          por_req,
   output logic          lvm_flag,
   output logic          lvm_irq
);
   localparam int SRC_BITS [SRC_NUM] = '{POR_BIT, EXT_BIT, WDT_BIT};

   if (DW < 8) begin : g_bad_dw
      $error("rcm_top: data width below 8");
   end
   if (IEN_BIT < CODE_W || FLAG_BIT <= IEN_BIT || FLAG_BIT >= DW) begin : g_bad_ctrl
      $error("rcm_top: control fields overlap");
   end

   logic [SRC_NUM-1:0] src_set;
   logic [SRC_NUM-1:0] src_q;
   logic               wr_stat;
   logic               wr_ctrl;
   logic               por_trip;
   logic               por_any;
   logic [CODE_W-1:0]  mon_code;
   logic               mon_ien;
   logic [DW-1:0]      status_byte;
   logic [DW-1:0]      ctrl_byte;

   assign wr_stat = wr_en && !reg_sel;
   assign wr_ctrl = wr_en &&  reg_sel;
   assign por_any = por_evt || por_trip;

   assign src_set[SRC_POR] = por_any;
   assign src_set[SRC_EXT] = ext_evt;
   assign src_set[SRC_WDT] = wdt_evt;

   for (genvar i = 0; i < SRC_NUM; i++) begin : g_src
      rcm_flag #(.CLR_ON_POR(i != SRC_POR)) u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (src_set[i]),
         .por_i   (por_any),
         .sw_clr_i(wr_stat && !wr_data[SRC_BITS[i]]),
         .q_o     (src_q[i])
      );
   end

   rcm_lvm #(
      .DW      (DW),
      .CODE_W  (CODE_W),
      .IEN_BIT (IEN_BIT),
      .FLAG_BIT(FLAG_BIT)
   ) u_lvm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_ctrl),
      .wdata_i   (wr_data),
      .trip_i    (lvm_trip),
      .code_o    (mon_code),
      .ien_o     (mon_ien),
      .flag_o    (lvm_flag),
      .por_trip_o(por_trip),
      .por_req_o (por_req)
   );

   always_comb begin
      status_byte = '0;
      for (int i = 0; i < SRC_NUM; i++) status_byte[SRC_BITS[i]] = src_q[i];
      ctrl_byte                = '0;
      ctrl_byte[CODE_W-1:0]    = mon_code;
      ctrl_byte[IEN_BIT]       = mon_ien;
      ctrl_byte[FLAG_BIT]      = lvm_flag;
   end

   assign rd_data = reg_sel ? ctrl_byte : status_byte;
   assign lvm_irq = lvm_flag && mon_ien;
endmodule

// File: rtl/rcm_top_chk.sv
module rcm_top_chk #(
   parameter int DW     = 8,
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              por_evt,
   input logic              wdt_evt,
   input logic              lvm_trip,
   input logic              reg_sel,
   input logic [DW-1:0]     rd_data,
   input logic              por_req,
   input logic              lvm_flag,
   input logic              lvm_irq,
   input logic [CODE_W-1:0] mon_code,
   input logic [DW-1:0]     status_byte
);
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (rd_data[7:4] == 4'h0 && !rd_data[2])); // R1
   AST_POR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt |=> status_byte[0]); // R2
   AST_WDT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_evt |=> status_byte[3]); // R3
   AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (lvm_trip && mon_code == '0) |=> !por_req); // R5
   AST_REQ_FROM_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      por_req |-> $past(lvm_trip)); // R6
   AST_IRQ_TRIP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (lvm_trip && (mon_code == 3'd3 || mon_code == 3'd4)) |=> (lvm_flag && !por_req)); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      lvm_irq |-> lvm_flag); // R7
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      32'(mon_code) <= 4); // R8
endmodule

bind rcm_top rcm_top_chk #(.DW(DW), .CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .por_evt    (por_evt),
   .wdt_evt    (wdt_evt),
   .lvm_trip   (lvm_trip),
   .reg_sel    (reg_sel),
   .rd_data    (rd_data),
   .por_req    (por_req),
   .lvm_flag   (lvm_flag),
   .lvm_irq    (lvm_irq),
   .mon_code   (mon_code),
   .status_byte(status_byte)
);

// File: tb/test_rcm_top.sv
`timescale 1ns/1ps
module test_rcm_top;
   typedef struct packed {
      logic [3:0] ev;   // {por, ext, wdt, trip}
      logic       we;
      logic       sel;
      logic [7:0] wd;
      logic [7:0] st;
      logic [7:0] ct;
      logic       req;
      logic       irq;
   } vec_t;

   function automatic vec_t mk(logic [3:0] ev, logic we, logic sel, logic [7:0] wd,
                               logic [7:0] st, logic [7:0] ct, logic req, logic irq);
      mk = '{ev, we, sel, wd, st, ct, req, irq};
   endfunction

   localparam int NV = 25;
   localparam vec_t TBL [NV] = '{
      mk(4'b1000, 0, 0, 8'h00, 8'h01, 8'h00, 0, 0), // R2 power-on sets flag
      mk(4'b0100, 0, 0, 8'h00, 8'h03, 8'h00, 0, 0), // R3 external sets
      mk(4'b0010, 0, 0, 8'h00, 8'h0B, 8'h00, 0, 0), // R3 watchdog sets
      mk(4'b0000, 1, 0, 8'hFE, 8'h0A, 8'h00, 0, 0), // R2 R4 R1 clear por only
      mk(4'b1000, 0, 0, 8'h00, 8'h01, 8'h00, 0, 0), // R3 power-on wipes ext/wdt
      mk(4'b0100, 0, 0, 8'h00, 8'h03, 8'h00, 0, 0), // R3
      mk(4'b0000, 1, 1, 8'h09, 8'h03, 8'h09, 0, 0), // R1 code 1 + enable
      mk(4'b0001, 0, 0, 8'h00, 8'h01, 8'h09, 1, 0), // R6 R2 R3 reset-mode trip
      mk(4'b0000, 0, 0, 8'h00, 8'h01, 8'h09, 0, 0), // R6 request is one pulse
      mk(4'b0000, 1, 1, 8'h0B, 8'h01, 8'h0B, 0, 0), // R7 code 3
      mk(4'b0001, 0, 0, 8'h00, 8'h01, 8'h8B, 0, 1), // R7 flag + irq
      mk(4'b0000, 1, 1, 8'h83, 8'h01, 8'h83, 0, 0), // R7 R4 enable off gates irq
      mk(4'b0000, 1, 1, 8'h0E, 8'h01, 8'h0B, 0, 0), // R8 R10 bad code kept, flag cleared
      mk(4'b0001, 1, 1, 8'h0B, 8'h01, 8'h8B, 0, 1), // R4 trip beats flag clear
      mk(4'b0000, 1, 1, 8'h08, 8'h01, 8'h08, 0, 0), // R10 clear, code 0
      mk(4'b0001, 0, 0, 8'h00, 8'h01, 8'h08, 0, 0), // R5 trip ignored
      mk(4'b0010, 1, 0, 8'h00, 8'h08, 8'h08, 0, 0), // R4 watchdog set beats clear
      mk(4'b0000, 1, 0, 8'hFF, 8'h08, 8'h08, 0, 0), // R1 R4 ones ignored
      mk(4'b0000, 1, 1, 8'h02, 8'h08, 8'h02, 0, 0), // R6 code 2
      mk(4'b0001, 0, 0, 8'h00, 8'h01, 8'h02, 1, 0), // R6 R3 trip wipes watchdog
      mk(4'b0000, 1, 1, 8'h04, 8'h01, 8'h04, 0, 0), // R7 code 4
      mk(4'b0001, 0, 0, 8'h00, 8'h01, 8'h84, 0, 0), // R7 flag, enable off
      mk(4'b0000, 1, 1, 8'h85, 8'h01, 8'h84, 0, 0), // R8 code 5 refused
      mk(4'b0000, 1, 1, 8'h87, 8'h01, 8'h84, 0, 0), // R8 code 7 refused
      mk(4'b1100, 0, 0, 8'h00, 8'h03, 8'h84, 0, 0)  // R4 ext set beats power-on clear
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_evt = 1'b0, ext_evt = 1'b0, wdt_evt = 1'b0, lvm_trip = 1'b0;
   logic       reg_sel = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       por_req, lvm_flag, lvm_irq;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   rcm_top i_rcm_top (
      .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_evt(ext_evt),
      .wdt_evt(wdt_evt), .lvm_trip(lvm_trip), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .por_req(por_req),
      .lvm_flag(lvm_flag), .lvm_irq(lvm_irq)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic peek(string tag, logic [7:0] st, logic [7:0] ct, logic req, logic irq);
      reg_sel = 1'b0; #0.5;
      chk({tag, " status"}, rd_data, st);
      reg_sel = 1'b1; #0.5;
      chk({tag, " control"}, rd_data, ct);
      chk({tag, " por_req"}, {7'd0, por_req}, {7'd0, req});
      chk({tag, " irq"}, {7'd0, lvm_irq}, {7'd0, irq});
   endtask

   initial begin
      #100000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      peek("R9 reset", 8'h00, 8'h00, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         {por_evt, ext_evt, wdt_evt, lvm_trip} = TBL[i].ev;
         wr_en   = TBL[i].we;
         reg_sel = TBL[i].sel;
         wr_data = TBL[i].wd;
         @(posedge clk);
         @(negedge clk);
         {por_evt, ext_evt, wdt_evt, lvm_trip} = 4'b0;
         wr_en = 1'b0;
         peek($sformatf("vec%0d", i), TBL[i].st, TBL[i].ct, TBL[i].req, TBL[i].irq);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule